// File: doc/BRIEF.md
# Feed-forward BCH component decoder (t = 2)

This block performs bounded-distance hard-decision decoding of a binary BCH code that may be shortened. It is the component decoder for the rows and columns of a product-like code. It accepts one received word per clock with a valid flag. Each word passes through three fixed pipeline stages: syndrome evaluation, a closed-form solution of the key equation, and a parallel root search over every received position. Each word comes out three clock edges later. No stage iterates and no stage keeps state other than its pipeline registers, so the block sustains a full word per clock.

The default field is GF(16), built on the primitive polynomial x^4 + x + 1. The full code length is 15, up to two errors are corrected, and a parameter sets how many high-order information positions are removed by shortening. Those positions are taken as zero and never appear on the input. A word whose syndromes are all zero is marked at the output of the syndrome stage. The locator registers downstream then keep their contents rather than toggle. For every word the block returns the corrected word, the vector of flipped positions, a failure flag and a clean flag.

Top module: `bch_ff_decoder`

## Requirements
- R1: A word sampled with `valid_i` high comes out with `valid_o` high exactly three rising edges later. Words may arrive on consecutive cycles and leave in arrival order. `valid_o` stays low for cycles with no input.
- R2: While `rst_ni` is low, every output is zero.
- R3: Bit i of `data_i` is the coefficient of x^i of the received polynomial. When both S1 = r(α) and S3 = r(α^3) are zero, the block sets `clean_o`=1 and `fail_o`=0, drives `err_loc_o` to zero, and outputs `data_o` equal to the input word.
- R4: A single bit error at any position 0..NS-1 of a codeword is corrected. `err_loc_o` is one-hot at that position and `data_o` is the codeword.
- R5: Any two bit errors inside 0..NS-1 are corrected, with exactly those two bits set in `err_loc_o`.
- R6: If S1 = 0 and S3 ≠ 0, the block sets `fail_o`=1 and `clean_o`=0, drives `err_loc_o` to zero, and passes `data_o` through unchanged.
- R7: If the number of locator roots among positions 0..NS-1 differs from the locator degree, the word is flagged as in R6. This includes roots that fall in the removed positions NS..14 and patterns of three or more errors.
- R8: While the registered syndromes of a valid word are all zero, the locator registers keep their values. A clean word that follows an erroneous one still reports clean with no corrections.
- R9: The codewords are the multiples of g(x) = x^8+x^7+x^6+x^4+1 whose degree is below NS. Each of them decodes as clean.
- R10: For every output word, `data_o` XOR the input word equals `err_loc_o`, and at most two bits are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Received word present |
| data_i | input | NS | Received word, bit i = coefficient of x^i |
| valid_o | output | 1 | Decoded word present |
| data_o | output | NS | Corrected word, or the input word on failure |
| err_loc_o | output | NS | Positions that were flipped |
| fail_o | output | 1 | Word lies beyond the correction radius |
| clean_o | output | 1 | All syndromes were zero |

## Verification
The assertions assume that `valid_i` and `data_i` are known and stable at every rising edge once reset is released. They also assume that `valid_i` is low while reset is held. They take no account of whether the word was ever a codeword. The relation between input and output, the latency and the mutual exclusion of the flags have to hold for any word. The bench changes its inputs only on falling edges and holds `valid_i` low throughout reset. It builds its words as multiples of g(x) with chosen error patterns, so every input stays well defined.

// File: rtl/bch_pkg.sv
package bch_pkg;

  localparam int unsigned GF_W = 16;
  typedef logic [GF_W-1:0] gf_t;

  typedef enum logic [1:0] {
    LOC_NONE = 2'd0,
    LOC_ONE  = 2'd1,
    LOC_TWO  = 2'd2,
    LOC_BAD  = 2'd3
  } loc_kind_e;

  // Polynomial-basis product, bit-parallel once m is fixed.
  function automatic gf_t gf_mul(input gf_t a, input gf_t b, input int unsigned m, input gf_t poly);
    gf_t acc;
    gf_t x;
    acc = '0;
    x   = a;
    for (int unsigned k = 0; k < GF_W; k++) begin
      if (k < m) begin
        if (((b >> k) & gf_t'(1)) != '0) acc ^= x;
        x = x << 1;
        if ((x & (gf_t'(1) << m)) != '0) x ^= poly;
      end
    end
    return acc;
  endfunction

  function automatic gf_t gf_alpha_pow(input int unsigned e, input int unsigned m, input gf_t poly);
    gf_t r;
    int unsigned ee;
    r  = gf_t'(1);
    ee = e % ((1 << m) - 1);
    for (int unsigned k = 0; k < ee; k++) begin
      r = r << 1;
      if ((r & (gf_t'(1) << m)) != '0) r ^= poly;
    end
    return r;
  endfunction

  // a^(2^m - 2) as a product of repeated squares.
  function automatic gf_t gf_inv(input gf_t a, input int unsigned m, input gf_t poly);
    gf_t sq;
    gf_t r;
    sq = a;
    r  = gf_t'(1);
    for (int unsigned k = 1; k < GF_W; k++) begin
      if (k < m) begin
        sq = gf_mul(sq, sq, m, poly);
        r  = gf_mul(r, sq, m, poly);
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/bch_syn_stage.sv
module bch_syn_stage import bch_pkg::*; #(
  parameter int unsigned M    = 4,
  parameter gf_t         PRIM = 16'h0013,
  parameter int unsigned NS   = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [NS-1:0] data_i,
  output logic          valid_o,
  output logic          zero_o,
  output logic [M-1:0]  s1_o,
  output logic [M-1:0]  s3_o,
  output logic [NS-1:0] data_o
);

  logic [M-1:0] a1_tab [NS];
  logic [M-1:0] a3_tab [NS];

  for (genvar i = 0; i < NS; i++) begin : g_pos
    localparam gf_t P1 = gf_alpha_pow(i, M, PRIM);
    localparam gf_t P3 = gf_alpha_pow(3 * i, M, PRIM);
    assign a1_tab[i] = P1[M-1:0];
    assign a3_tab[i] = P3[M-1:0];
  end

  logic [M-1:0] s1_d, s3_d;

  always_comb begin
    s1_d = '0;
    s3_d = '0;
    for (int i = 0; i < NS; i++) begin
      if (data_i[i]) begin
        s1_d ^= a1_tab[i];
        s3_d ^= a3_tab[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      zero_o  <= 1'b0;
      s1_o    <= '0;
      s3_o    <= '0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        zero_o <= (s1_d == '0) && (s3_d == '0);
        s1_o   <= s1_d;
        s3_o   <= s3_d;
        data_o <= data_i;
      end
    end
  end

endmodule

// File: rtl/bch_kes_stage.sv
module bch_kes_stage import bch_pkg::*; #(
  parameter int unsigned M    = 4,
  parameter gf_t         PRIM = 16'h0013,
  parameter int unsigned NS   = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          zero_i,
  input  logic [M-1:0]  s1_i,
  input  logic [M-1:0]  s3_i,
  input  logic [NS-1:0] data_i,
  output logic          valid_o,
  output logic          zero_o,
  output loc_kind_e     kind_o,
  output logic [M-1:0]  sig1_o,
  output logic [M-1:0]  sig2_o,
  output logic [NS-1:0] data_o
);

  function automatic logic [M-1:0] fmul(input logic [M-1:0] a, input logic [M-1:0] b);
    gf_t r;
    r = gf_mul(gf_t'(a), gf_t'(b), M, PRIM);
    return r[M-1:0];
  endfunction

  function automatic logic [M-1:0] finv(input logic [M-1:0] a);
    gf_t r;
    r = gf_inv(gf_t'(a), M, PRIM);
    return r[M-1:0];
  endfunction

  logic [M-1:0] s1_sq, s1_cu, s1_inv;
  loc_kind_e    kind_d;
  logic [M-1:0] sig1_d, sig2_d;

  assign s1_sq  = fmul(s1_i, s1_i);
  assign s1_cu  = fmul(s1_sq, s1_i);
  assign s1_inv = finv(s1_i);

  // Closed-form locator for two errors: sigma1 = S1, sigma2 = (S3 + S1^3) / S1.
  always_comb begin
    kind_d = LOC_NONE;
    sig1_d = '0;
    sig2_d = '0;
    if (s1_i == '0) begin
      kind_d = (s3_i == '0) ? LOC_NONE : LOC_BAD;
    end else if (s1_cu == s3_i) begin
      kind_d = LOC_ONE;
      sig1_d = s1_i;
    end else begin
      kind_d = LOC_TWO;
      sig1_d = s1_i;
      sig2_d = fmul(s3_i ^ s1_cu, s1_inv);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      zero_o  <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        zero_o <= zero_i;
        data_o <= data_i;
      end
    end
  end

  // Locator registers only load for words that carry errors.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_o <= LOC_NONE;
      sig1_o <= '0;
      sig2_o <= '0;
    end else if (valid_i && !zero_i) begin
      kind_o <= kind_d;
      sig1_o <= sig1_d;
      sig2_o <= sig2_d;
    end
  end

endmodule

// File: rtl/bch_chien_stage.sv
module bch_chien_stage import bch_pkg::*; #(
  parameter int unsigned M    = 4,
  parameter gf_t         PRIM = 16'h0013,
  parameter int unsigned NS   = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          zero_i,
  input  loc_kind_e     kind_i,
  input  logic [M-1:0]  sig1_i,
  input  logic [M-1:0]  sig2_i,
  input  logic [NS-1:0] data_i,
  output logic          valid_o,
  output logic [NS-1:0] data_o,
  output logic [NS-1:0] loc_o,
  output logic          fail_o,
  output logic          clean_o
);

  localparam int unsigned N  = (1 << M) - 1;
  localparam int unsigned CW = $clog2(NS + 1);
  localparam logic [M-1:0] ONE = M'(1);

  function automatic logic [M-1:0] fmul(input logic [M-1:0] a, input logic [M-1:0] b);
    gf_t r;
    r = gf_mul(gf_t'(a), gf_t'(b), M, PRIM);
    return r[M-1:0];
  endfunction

  logic [NS-1:0] root;

  // Root at alpha^-i marks an error at position i.
  for (genvar i = 0; i < NS; i++) begin : g_eval
    localparam int unsigned E1 = (N - i) % N;
    localparam int unsigned E2 = (2 * (N - i)) % N;
    localparam gf_t P1 = gf_alpha_pow(E1, M, PRIM);
    localparam gf_t P2 = gf_alpha_pow(E2, M, PRIM);
    assign root[i] = ((fmul(sig1_i, P1[M-1:0]) ^ fmul(sig2_i, P2[M-1:0])) == ONE);
  end

  logic [CW-1:0] cnt, deg;
  logic          ok;
  logic [NS-1:0] loc_d;
  logic          fail_d;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NS; i++) cnt = cnt + CW'(root[i]);
    unique case (kind_i)
      LOC_ONE: deg = CW'(1);
      LOC_TWO: deg = CW'(2);
      default: deg = '0;
    endcase
    ok = (kind_i == LOC_ONE || kind_i == LOC_TWO) && (cnt == deg);
    if (zero_i) begin
      loc_d  = '0;
      fail_d = 1'b0;
    end else if (ok) begin
      loc_d  = root;
      fail_d = 1'b0;
    end else begin
      loc_d  = '0;
      fail_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      loc_o   <= '0;
      fail_o  <= 1'b0;
      clean_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        data_o  <= data_i ^ loc_d;
        loc_o   <= loc_d;
        fail_o  <= fail_d;
        clean_o <= zero_i;
      end
    end
  end

endmodule

// File: rtl/bch_ff_decoder.sv
module bch_ff_decoder import bch_pkg::*; #(
  parameter int unsigned M     = 4,
  parameter gf_t         PRIM  = 16'h0013,
  parameter int unsigned SHORT = 2,
  localparam int unsigned NS   = (1 << M) - 1 - SHORT
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [NS-1:0] data_i,
  output logic          valid_o,
  output logic [NS-1:0] data_o,
  output logic [NS-1:0] err_loc_o,
  output logic          fail_o,
  output logic          clean_o
);

  logic          syn_valid, syn_zero;
  logic [M-1:0]  syn_s1, syn_s3;
  logic [NS-1:0] syn_data;

  logic          kes_valid, kes_zero;
  loc_kind_e     kes_kind;
  logic [M-1:0]  kes_sig1, kes_sig2;
  logic [NS-1:0] kes_data;

  bch_syn_stage #(.M(M), .PRIM(PRIM), .NS(NS)) u_syn (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .data_i  (data_i),
    .valid_o (syn_valid),
    .zero_o  (syn_zero),
    .s1_o    (syn_s1),
    .s3_o    (syn_s3),
    .data_o  (syn_data)
  );

  bch_kes_stage #(.M(M), .PRIM(PRIM), .NS(NS)) u_kes (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (syn_valid),
    .zero_i  (syn_zero),
    .s1_i    (syn_s1),
    .s3_i    (syn_s3),
    .data_i  (syn_data),
    .valid_o (kes_valid),
    .zero_o  (kes_zero),
    .kind_o  (kes_kind),
    .sig1_o  (kes_sig1),
    .sig2_o  (kes_sig2),
    .data_o  (kes_data)
  );

  bch_chien_stage #(.M(M), .PRIM(PRIM), .NS(NS)) u_chien (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (kes_valid),
    .zero_i  (kes_zero),
    .kind_i  (kes_kind),
    .sig1_i  (kes_sig1),
    .sig2_i  (kes_sig2),
    .data_i  (kes_data),
    .valid_o (valid_o),
    .data_o  (data_o),
    .loc_o   (err_loc_o),
    .fail_o  (fail_o),
    .clean_o (clean_o)
  );

endmodule

// File: rtl/bch_ff_decoder_chk.sv
module bch_ff_decoder_chk #(
  parameter int unsigned NS = 13,
  parameter int unsigned M  = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [NS-1:0] data_i,
  input logic          valid_o,
  input logic [NS-1:0] data_o,
  input logic [NS-1:0] err_loc_o,
  input logic          fail_o,
  input logic          clean_o,
  input logic          syn_valid_i,
  input logic          syn_zero_i,
  input logic [M-1:0]  sig1_i,
  input logic [M-1:0]  sig2_i
);

  logic [1:0] since_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3) && $past(valid_i, 3) |-> valid_o);

  assert_no_spurious_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3) && !$past(valid_i, 3) |-> !valid_o);

  assert_clean_pass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3) && valid_o && clean_o |->
      (err_loc_o == '0) && !fail_o && (data_o == $past(data_i, 3)));

  assert_fail_pass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && fail_o |-> (err_loc_o == '0) && !clean_o);

  assert_locator_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    syn_valid_i && syn_zero_i |=> $stable(sig1_i) && $stable(sig2_i));

  assert_fix_relation_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3) && valid_o |->
      ((data_o ^ $past(data_i, 3)) == err_loc_o) && ($countones(err_loc_o) <= 2));

  assert_flags_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $onehot0({fail_o, clean_o}));

endmodule

bind bch_ff_decoder bch_ff_decoder_chk #(.NS(NS), .M(M)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .data_i      (data_i),
  .valid_o     (valid_o),
  .data_o      (data_o),
  .err_loc_o   (err_loc_o),
  .fail_o      (fail_o),
  .clean_o     (clean_o),
  .syn_valid_i (syn_valid),
  .syn_zero_i  (syn_zero),
  .sig1_i      (kes_sig1),
  .sig2_i      (kes_sig2)
);

// File: tb/sim_bch_ff_decoder.sv
module sim_bch_ff_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int NS         = 13;
  localparam int KS         = 5;
  localparam int LIMIT      = 20000;
  localparam logic [NS-1:0] GEN = NS'(9'h1D1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid_i = 1'b0;
  logic [NS-1:0] data_i = '0;
  logic          valid_o;
  logic [NS-1:0] data_o, err_loc_o;
  logic          fail_o, clean_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [NS-1:0] data;
    logic [NS-1:0] loc;
    logic          fail;
    logic          clean;
    int            issue;
    string         tag;
  } item_t;

  item_t exp_q[$];

  bch_ff_decoder #(.SHORT(2)) u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .valid_i   (valid_i),
    .data_i    (data_i),
    .valid_o   (valid_o),
    .data_o    (data_o),
    .err_loc_o (err_loc_o),
    .fail_o    (fail_o),
    .clean_o   (clean_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // GF(16) with x^4 = x + 1
  function automatic logic [3:0] alpha(input int e);
    logic [3:0] a = 4'd1;
    for (int k = 0; k < (e % 15); k++) a = {a[2:0], 1'b0} ^ (a[3] ? 4'h3 : 4'h0);
    return a;
  endfunction

  function automatic logic syn_zero(input logic [NS-1:0] r);
    logic [3:0] s1 = '0;
    logic [3:0] s3 = '0;
    for (int i = 0; i < NS; i++) if (r[i]) begin
      s1 ^= alpha(i);
      s3 ^= alpha(3 * i);
    end
    return (s1 == '0) && (s3 == '0);
  endfunction

  function automatic logic [NS-1:0] encode(input logic [KS-1:0] u);
    logic [NS-1:0] c = '0;
    for (int j = 0; j < KS; j++) if (u[j]) c ^= GEN << j;
    return c;
  endfunction

  function automatic logic [NS-1:0] rem_pos(input int p);
    logic [15:0] v = 16'd1 << p;
    for (int d = 15; d >= 8; d--) if (v[d]) v ^= 16'(9'h1D1) << (d - 8);
    return NS'(v[7:0]);
  endfunction

  // Nearest word within two flips, searched exhaustively.
  function automatic item_t model(input logic [NS-1:0] r);
    item_t it;
    logic  found = 1'b0;
    it.data = r; it.loc = '0; it.fail = 1'b0; it.clean = 1'b0; it.issue = 0; it.tag = "";
    if (syn_zero(r)) begin
      it.clean = 1'b1;
    end else begin
      for (int i = 0; i < NS; i++)
        if (!found && syn_zero(r ^ (NS'(1) << i))) begin
          found = 1'b1; it.loc = NS'(1) << i;
        end
      for (int i = 0; i < NS; i++)
        for (int j = i + 1; j < NS; j++)
          if (!found && syn_zero(r ^ (NS'(1) << i) ^ (NS'(1) << j))) begin
            found = 1'b1; it.loc = (NS'(1) << i) | (NS'(1) << j);
          end
      if (found) it.data = r ^ it.loc;
      else it.fail = 1'b1;
    end
    return it;
  endfunction

  task automatic send(input logic [NS-1:0] r, input string tag);
    item_t e;
    @(negedge clk);
    valid_i = 1'b1;
    data_i  = r;
    e = model(r);
    e.issue = cyc;
    e.tag   = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      valid_i = 1'b0;
      data_i  = '0;
    end
  endtask

  function automatic logic [NS-1:0] rnd_cw();
    return encode(KS'($urandom_range(2**KS - 1)));
  endfunction

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R1: unexpected valid_o, actual 1 expected 0");
      end else begin
        item_t e;
        e = exp_q.pop_front();
        if (data_o !== e.data || err_loc_o !== e.loc || fail_o !== e.fail ||
            clean_o !== e.clean || cyc != e.issue + 3) begin
          fails++;
          $display("FAIL %s: actual data=%h loc=%h fail=%b clean=%b cyc=%0d expected data=%h loc=%h fail=%b clean=%b cyc=%0d",
                   e.tag, data_o, err_loc_o, fail_o, clean_o, cyc,
                   e.data, e.loc, e.fail, e.clean, e.issue + 3);
        end
      end
    end
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (valid_o !== 1'b0 || data_o !== '0 || err_loc_o !== '0 || fail_o !== 1'b0 || clean_o !== 1'b0) begin
      fails++;
      $display("FAIL R2: actual v=%b d=%h l=%h f=%b c=%b expected all zero",
               valid_o, data_o, err_loc_o, fail_o, clean_o);
    end
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R3 / R9: clean words
    send('0, "R3");
    send(encode(5'd1), "R9");
    send(encode(5'd5), "R9");
    send(encode(5'd31), "R9");
    idle(1);

    // R4: single error at every position
    for (int p = 0; p < NS; p++) send(rnd_cw() ^ (NS'(1) << p), "R4");
    idle(2);

    // R5: pairs including both ends
    send(rnd_cw() ^ NS'(13'h0003), "R5");
    send(rnd_cw() ^ NS'(13'h1001), "R5");
    send(rnd_cw() ^ NS'(13'h1800), "R5");
    for (int k = 0; k < 20; k++) begin
      int p1 = $urandom_range(NS - 1);
      int p2 = (p1 + 1 + $urandom_range(NS - 2)) % NS;
      send(rnd_cw() ^ (NS'(1) << p1) ^ (NS'(1) << p2), "R5");
    end
    idle(1);

    // R6: bits 0,1,4 give S1 = 0, S3 != 0
    send(NS'(13'h0013), "R6");
    send(rnd_cw() ^ NS'(13'h0013), "R6");
    idle(1);

    // R7: roots in removed positions, and triple errors
    send(rem_pos(13), "R7");
    send(rnd_cw() ^ rem_pos(14), "R7");
    for (int k = 0; k < 30; k++) begin
      int p1 = $urandom_range(NS - 1);
      int p2 = (p1 + 1 + $urandom_range(NS - 2)) % NS;
      int p3;
      do p3 = $urandom_range(NS - 1); while (p3 == p1 || p3 == p2);
      send(rnd_cw() ^ (NS'(1) << p1) ^ (NS'(1) << p2) ^ (NS'(1) << p3), "R7");
    end

    // R8: clean words directly behind an erroneous one
    send(rnd_cw() ^ NS'(13'h0410), "R8");
    send(rnd_cw(), "R8");
    send(rnd_cw(), "R8");
    idle(3);

    // R1: gaps, then a dense mixed stream (R10 relation checked on each)
    send(rnd_cw() ^ NS'(13'h0020), "R1");
    idle(2);
    send(rnd_cw(), "R1");
    idle(1);
    for (int k = 0; k < 120; k++) begin
      logic [NS-1:0] e = '0;
      int w = $urandom_range(3);
      for (int j = 0; j < w; j++) e[$urandom_range(NS - 1)] = 1'b1;
      send(rnd_cw() ^ e, "R10");
    end
    idle(8);

    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R1: actual %0d words pending expected 0", exp_q.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule